// File: doc/BRIEF.md
# Gated Prescaled Peripheral Timer

This block is a 16-bit up-counter for a peripheral subsystem. It picks its count source from one of two kinds of input. The first is an internal count enable that pulses at the instruction-clock rate. The second is one of four external inputs; the block resynchronizes each of these and counts its rising edges. A power-of-two prescaler divides the chosen source before it reaches the counter. The counter compares itself with a period register. On a match it wraps to zero and raises a one-cycle match pulse.

Software controls the timer through a small register port with three locations: a control word, the live count and the period. In gated accumulation mode the timer counts internal ticks only while a gate input is high, and it reports each end of the gate window with a one-cycle event. When an idle input is asserted, a control bit decides whether the timer stops or keeps running. A pairing input hands control of the counter to a master timer, which then advances it through a separate tick input.

Top module: `gtmr_top`

## Requirements
- R1: Register port addresses are 0 for control, 1 for count and 2 for period. `bus_rdata` shows the addressed register one cycle after `bus_addr` is applied. The implemented control bits are 15 (run), 13 (halt in idle), 9:8 (external select), 7 (gate enable), 5:4 (divide) and 1 (external source). Writing 0xFFFF to control reads back 0xA3B2.
- R2: After reset, control reads 0x0000, count reads 0x0000 and period reads 0xFFFF.
- R3: Divide field values 0, 1, 2 and 3 advance the counter once per 1, 8, 64 and 256 source pulses.
- R4: While the run bit is 0 and pairing is off, the count holds.
- R5: With bit 1 clear, each cycle with `int_tick` high is one source pulse. With bit 1 set, the source is the rising edges of `ext_in[select]` after a two-flop synchronizer. In that case `int_tick` and the unselected inputs have no effect.
- R6: With the gate bit set and the internal source selected, pulses count only while the synchronized `gate_in` is high. With the external source selected, the gate bit is ignored.
- R7: With the halt-in-idle bit set and `idle_in` high, the count holds. With the bit clear, counting continues during idle.
- R8: A control write made while the run bit is 1 clears the prescaler's partial count.
- R9: While `pair_en` is high, the counter advances once per `pair_tick` cycle, and the control bits and `int_tick` are ignored.
- R10: An advance that finds count equal to period sets count to 0, and `match_irq` is high for exactly the following cycle.
- R11: A bus write to the count register takes priority over an advance in the same cycle.
- R12: In gated mode, a falling edge of the synchronized gate gives a one-cycle `gate_end` pulse, and counting stays halted while the gate is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| int_tick | input | 1 | Internal count enable (instruction-clock rate) |
| ext_in | input | 4 | External count sources, selected by control bits 9:8 |
| gate_in | input | 1 | Gate for accumulation mode |
| idle_in | input | 1 | System idle indication |
| pair_en | input | 1 | Counter slaved to a master timer |
| pair_tick | input | 1 | Advance request from the master timer |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| match_irq | output | 1 | One-cycle period match pulse |
| gate_end | output | 1 | One-cycle end-of-gate event |

## Verification
The following properties are checked on every cycle:
- The count holds when the timer is stopped, halted in idle, or gated off.
- A match pulse always coincides with a zero count.
- The prescaler is empty after any clear.
- The synchronizer shifts without loss.
- Control reads never show unimplemented bits.

Only the bench scenarios can show the following:
- The division ratios of each divide setting.
- That the prescaler clear on a control write changes the count.
- Which external input the select field routes to the counter.
- That the gate bit is ignored when the external source is selected.
- Pairing priority.
- Bus-over-advance priority.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_COUNT  = 2'd1,
    REG_PERIOD = 2'd2
  } reg_sel_e;

  localparam int B_RUN      = 15;
  localparam int B_IDLESTOP = 13;
  localparam int B_SRC_LO   = 8;
  localparam int B_GATE     = 7;
  localparam int B_DIV_LO   = 4;
  localparam int B_EXT      = 1;
  localparam logic [DW-1:0] CTRL_MASK = 16'hA3B2;

  // log2 of the division ratio for each divide code
  function automatic int div_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 3;
      2'd2:    return 6;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/gtmr_sync.sv
module gtmr_sync #(
  parameter int N      = 5,
  parameter int STAGES = 2
)(
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], din[i]};
    end
    assign lvl[i] = sh[STAGES-1];

    // R5: the synchronized level follows the first stage one cycle later
    assert_sync_shift_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(sh[0]) |=> sh[1]);
  end
endmodule

// File: rtl/gtmr_prescale.sv
module gtmr_prescale import gtmr_pkg::*; #(
  parameter int PRE_W = 8
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       pulse,
  input  logic [1:0] div_sel,
  output logic       tick
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] term;

  always_comb term = PRE_W'((32'd1 << div_shift(div_sel)) - 32'd1);

  assign tick = pulse && !clr && (pcnt >= term);

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (pulse)  pcnt <= (pcnt >= term) ? '0 : pcnt + 1'b1;
  end

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pcnt == '0));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top import gtmr_pkg::*; #(
  parameter int N_EXT       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 8
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             int_tick,
  input  logic [N_EXT-1:0] ext_in,
  input  logic             gate_in,
  input  logic             idle_in,
  input  logic             pair_en,
  input  logic             pair_tick,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             match_irq,
  output logic             gate_end
);
  localparam int SEL_W = $clog2(N_EXT);

  logic [DW-1:0]    ctrl_q, cnt_q, per_q;
  logic [N_EXT:0]   sync_lvl;
  logic [N_EXT-1:0] ext_lvl;
  logic             gate_lvl, gate_prev, ext_prev, ext_sel_lvl;
  logic             wr_ctrl, wr_cnt, run, ext_mode, gated, idle_halt;
  logic             src_pulse, gate_ok, pre_pulse, pre_clr, pre_tick, adv;

  gtmr_sync #(.N(N_EXT + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din({gate_in, ext_in}), .lvl(sync_lvl));

  assign ext_lvl  = sync_lvl[N_EXT-1:0];
  assign gate_lvl = sync_lvl[N_EXT];

  assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
  assign wr_cnt    = bus_wr && (bus_addr == REG_COUNT);
  assign run       = ctrl_q[B_RUN];
  assign ext_mode  = ctrl_q[B_EXT];
  assign gated     = run && !ext_mode && ctrl_q[B_GATE];
  assign idle_halt = ctrl_q[B_IDLESTOP] && idle_in;

  assign ext_sel_lvl = ext_lvl[ctrl_q[B_SRC_LO +: SEL_W]];
  assign src_pulse   = ext_mode ? (ext_sel_lvl && !ext_prev) : int_tick;
  assign gate_ok     = ext_mode || !ctrl_q[B_GATE] || gate_lvl;
  assign pre_pulse   = !pair_en && run && !idle_halt && gate_ok && src_pulse;
  assign pre_clr     = wr_ctrl && run;

  gtmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(pre_clr), .pulse(pre_pulse),
    .div_sel(ctrl_q[B_DIV_LO +: 2]), .tick(pre_tick));

  assign adv = pair_en ? pair_tick : pre_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_prev  <= 1'b0;
      gate_prev <= 1'b0;
      gate_end  <= 1'b0;
    end else begin
      ext_prev  <= ext_sel_lvl;
      gate_prev <= gate_lvl;
      gate_end  <= !pair_en && gated && gate_prev && !gate_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      per_q  <= '1;
    end else if (bus_wr) begin
      if (bus_addr == REG_CTRL)   ctrl_q <= bus_wdata & CTRL_MASK;
      if (bus_addr == REG_PERIOD) per_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      match_irq <= 1'b0;
    end else begin
      match_irq <= 1'b0;
      if (wr_cnt) begin
        cnt_q <= bus_wdata;
      end else if (adv) begin
        if (cnt_q == per_q) begin
          cnt_q     <= '0;
          match_irq <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        REG_CTRL:   bus_rdata <= ctrl_q;
        REG_COUNT:  bus_rdata <= cnt_q;
        REG_PERIOD: bus_rdata <= per_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  assert_match_wraps_R10: assert property (@(posedge clk) disable iff (rst)
    match_irq |-> (cnt_q == '0));

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!pair_en && !run && !wr_cnt) |=> $stable(cnt_q));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!pair_en && idle_halt && !wr_cnt) |=> $stable(cnt_q));

  assert_gate_halt_R6: assert property (@(posedge clk) disable iff (rst)
    (!pair_en && gated && !gate_lvl && !wr_cnt) |=> $stable(cnt_q));

  assert_ctrl_unimpl_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == REG_CTRL) |=> ((bus_rdata & ~CTRL_MASK) == '0));
endmodule

// File: tb/gtmr_top_tb_top.sv
`timescale 1ns/1ps
module gtmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        int_tick = 1'b0;
  logic [3:0]  ext_in = '0;
  logic        gate_in = 1'b0, idle_in = 1'b0, pair_en = 1'b0, pair_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        match_irq, gate_end;

  int checks = 0, errors = 0, irq_seen = 0, gend_seen = 0;
  bit done = 0;

  typedef struct { int kind; int exp; string tag; } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  gtmr_top dut_i (
    .clk(clk), .rst(rst), .int_tick(int_tick), .ext_in(ext_in), .gate_in(gate_in),
    .idle_in(idle_in), .pair_en(pair_en), .pair_tick(pair_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .match_irq(match_irq), .gate_end(gate_end));

  always @(negedge clk) begin
    if (match_irq) irq_seen++;
    if (gate_end)  gend_seen++;
  end

  // monitor: pops expectations and compares against the design
  always @(negedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      item_t it;
      int act;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? int'(bus_rdata) : (it.kind == 1) ? irq_seen : gend_seen;
      checks++;
      if (act != it.exp) begin
        errors++;
        $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    sb_q.push_back('{0, exp, tag});
    @(negedge clk);
  endtask

  task automatic ev_chk(input int kind, input int exp, input string tag);
    sb_q.push_back('{kind, exp, tag});
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    int_tick = 1'b1;
    repeat (n) @(negedge clk);
    int_tick = 1'b0;
  endtask

  task automatic ext_pulse(input int idx, input int n);
    repeat (n) begin
      ext_in[idx] = 1'b1; cyc(3);
      ext_in[idx] = 1'b0; cyc(3);
    end
    cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    rd_chk(0, 16'h0000, "R2 ctrl reset");
    rd_chk(1, 16'h0000, "R2 count reset");
    rd_chk(2, 16'hFFFF, "R2 period reset");

    wr(0, 16'hFFFF);
    rd_chk(0, 16'hA3B2, "R1 ctrl mask");
    wr(0, 16'h0000);

    wr(0, 16'h8000); pulses(5);
    rd_chk(1, 5, "R5 internal source 1:1");
    wr(0, 16'h0000); pulses(3);
    rd_chk(1, 5, "R4 stopped holds");

    wr(1, 0); wr(0, 16'h8010); pulses(20);
    rd_chk(1, 2, "R3 divide by 8");
    wr(0, 16'h8020); pulses(61);
    rd_chk(1, 2, "R8 prescaler cleared by write");
    pulses(3);
    rd_chk(1, 3, "R3 divide by 64");
    wr(1, 0); wr(0, 16'h8030); pulses(512);
    rd_chk(1, 2, "R3 divide by 256");

    wr(0, 16'h8000);
    int_tick = 1'b1; wr(1, 16'h1234); int_tick = 1'b0;
    rd_chk(1, 16'h1234, "R11 bus write wins");

    wr(2, 3); wr(1, 0); pulses(4);
    rd_chk(1, 0, "R10 wrap at period");
    ev_chk(1, 1, "R10 match pulse count");
    pulses(2);
    rd_chk(1, 2, "R10 count after wrap");
    pulses(2);
    ev_chk(1, 2, "R10 second match");
    wr(2, 16'hFFFF);

    wr(1, 0); wr(0, 16'h8202);
    int_tick = 1'b1;
    ext_pulse(2, 3); ext_pulse(1, 2);
    int_tick = 1'b0;
    rd_chk(1, 3, "R5 ext select 2 only");
    wr(0, 16'h8302); ext_pulse(3, 2);
    rd_chk(1, 5, "R5 ext select 3");
    wr(0, 16'h8382); gate_in = 1'b0; ext_pulse(3, 2);
    rd_chk(1, 7, "R6 gate ignored with external");

    wr(1, 0); wr(0, 16'h8080); pulses(5);
    rd_chk(1, 0, "R6 gate low blocks");
    gate_in = 1'b1; cyc(2); pulses(4);
    rd_chk(1, 4, "R6 gate high counts");
    gate_in = 1'b0; cyc(4);
    ev_chk(2, 1, "R12 gate end pulse");
    pulses(3);
    rd_chk(1, 4, "R12 halted after gate end");

    wr(1, 0); wr(0, 16'hA000); idle_in = 1'b1; pulses(3);
    rd_chk(1, 0, "R7 halt in idle");
    wr(0, 16'h8000); pulses(3);
    rd_chk(1, 3, "R7 runs in idle when bit clear");
    idle_in = 1'b0;

    wr(0, 16'h0000); pair_en = 1'b1; pulses(3);
    pair_tick = 1'b1; cyc(4); pair_tick = 1'b0;
    rd_chk(1, 7, "R9 paired counting");
    pair_en = 1'b0;

    cyc(2);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule